// File: doc/BRIEF.md
# Mixed-Width Element Operation Unit

This unit applies one integer operation to a single pair of vector elements whose source and destination element widths may all differ. Each source value arrives with its own width code. A destination width code, a signed/unsigned control, an operation select and a predicate bit come with it. The unit extends both sources to a shared working width, which is the wider of the two source widths. It computes the result at that width, then fits the result to the destination width before it registers the value.

A sequencer that walks the elements of a vector feeds this unit one element pair per cycle. The sequencer reads the register file on its way in and writes the result back on its way out. Only one datapath is needed. Per-operand extension to the working width, plus one final adjustment to the destination width, takes the place of a separate path for every combination of the three widths.

Top module: `mw_elem_unit`

## Requirements
- R1: Width codes are 2 bits: 0 means the full word width XLEN (64 by default), 1 means 8 bits, 2 means 16 bits and 3 means 32 bits. The working width is the larger of the widths coded by `a_w_i` and `b_w_i`.
- R2: Each source is first reduced to its own coded width. When `sign_i` is 1 it is then sign-extended to the working width, and when `sign_i` is 0 it is zero-extended.
- R3: `op_i` selects 0 add, 1 subtract (a minus b), 2 and, 3 or, 4 xor, 5 shift left logical, 6 shift right logical, 7 shift right arithmetic. The raw result keeps only the low working-width bits.
- R4: The shift amount is the extended b operand modulo the working width. The arithmetic right shift fills from bit (working width - 1) of the extended a operand, whatever the value of `sign_i`.
- R5: The working-width result is extended from the working width (sign if `sign_i` is 1, zero otherwise) and then cut to the destination width coded by `d_w_i`. `res_o` carries those destination bits. Every bit above them equals the destination sign bit when `sign_i` is 1 and is 0 when `sign_i` is 0.
- R6: When `valid_i` and `pred_i` are both 1 at a rising clock edge, `valid_o` is 1 for the following cycle and `res_o` holds that element's result from then on.
- R7: When `valid_i` is 1 and `pred_i` is 0, the element is skipped: `valid_o` stays 0 in the next cycle and `res_o` keeps its previous value.
- R8: While `rst_n` is low, `valid_o` is 0 and `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An element pair is presented this cycle |
| pred_i | input | 1 | Predicate bit of the element; 0 skips it |
| op_i | input | 3 | Operation select |
| sign_i | input | 1 | 1 selects sign extension, 0 selects zero extension |
| a_i | input | XLEN | Source a value (low bits used per its width) |
| a_w_i | input | 2 | Width code of source a |
| b_i | input | XLEN | Source b value (low bits used per its width) |
| b_w_i | input | 2 | Width code of source b |
| d_w_i | input | 2 | Width code of the destination |
| valid_o | output | 1 | Result strobe, one cycle after an accepted element |
| res_o | output | XLEN | Registered result, extended to XLEN per R5 |

## Verification
The assertions take for granted that every control input is a defined 0 or 1 at each rising edge while `valid_i` is high. They also assume that `d_w_i` and `sign_i` are those of the element being captured, because the fill check looks back one cycle at them. The stimulus drives every input on the falling edge, so nothing changes near a capture edge. It sets the controls on every cycle, including idle cycles, and it fills the bits above a source's width with random data to show that those bits are ignored.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SLL = 3'd5,
        OP_SRL = 3'd6,
        OP_SRA = 3'd7
    } mw_op_e;

    typedef logic [1:0] wcode_t;

    // Number of bits a width code stands for (code 0 = full word).
    function automatic int unsigned code_bits(wcode_t c, int unsigned xlen);
        case (c)
            2'd1:    return 8;
            2'd2:    return 16;
            2'd3:    return 32;
            default: return xlen;
        endcase
    endfunction

endpackage

// File: rtl/mw_width_arb.sv
module mw_width_arb
    import mw_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    localparam int unsigned BW  = $clog2(XLEN + 1)
) (
    input  wcode_t        a_w_i,
    input  wcode_t        b_w_i,
    output logic [BW-1:0] a_bits_o,
    output logic [BW-1:0] b_bits_o,
    output logic [BW-1:0] work_bits_o
);

    always_comb begin
        a_bits_o    = BW'(code_bits(a_w_i, XLEN));
        b_bits_o    = BW'(code_bits(b_w_i, XLEN));
        work_bits_o = (a_bits_o > b_bits_o) ? a_bits_o : b_bits_o;
    end

    always_comb begin
        AST_WORK_IS_MAX: assert ((work_bits_o >= a_bits_o) && (work_bits_o >= b_bits_o)
            && ((work_bits_o == a_bits_o) || (work_bits_o == b_bits_o))); // R1
    end

endmodule

// File: rtl/mw_extend.sv
module mw_extend #(
    parameter int unsigned XLEN = 64,
    localparam int unsigned BW  = $clog2(XLEN + 1),
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [BW-1:0]   nbits_i,
    input  logic            sgn_i,
    output logic [XLEN-1:0] ext_o
);

    logic [SHW-1:0] top_idx;
    logic           fill;

    always_comb begin
        top_idx = SHW'(nbits_i - BW'(1));
        fill    = sgn_i & val_i[top_idx];
        for (int i = 0; i < int'(XLEN); i++) begin
            ext_o[i] = (i < int'(nbits_i)) ? val_i[i] : fill;
        end
    end

endmodule

// File: rtl/mw_alu.sv
module mw_alu
    import mw_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    localparam int unsigned BW  = $clog2(XLEN + 1),
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [BW-1:0]   work_bits_i,
    input  mw_op_e          op_i,
    output logic [XLEN-1:0] raw_o
);

    logic [SHW-1:0]  shamt;
    logic [SHW-1:0]  top_idx;
    logic [XLEN-1:0] work_mask;
    logic [XLEN-1:0] a_sx;
    logic [XLEN-1:0] full;

    always_comb begin
        top_idx = SHW'(work_bits_i - BW'(1));
        shamt   = b_i[SHW-1:0] & top_idx;
        for (int i = 0; i < int'(XLEN); i++) begin
            work_mask[i] = (i < int'(work_bits_i));
            a_sx[i]      = (i < int'(work_bits_i)) ? a_i[i] : a_i[top_idx];
        end
        case (op_i)
            OP_ADD:  full = a_i + b_i;
            OP_SUB:  full = a_i - b_i;
            OP_AND:  full = a_i & b_i;
            OP_OR:   full = a_i | b_i;
            OP_XOR:  full = a_i ^ b_i;
            OP_SLL:  full = a_i << shamt;
            OP_SRL:  full = (a_i & work_mask) >> shamt;
            default: full = XLEN'($signed(a_sx) >>> shamt);
        endcase
        raw_o = full & work_mask;
    end

    always_comb begin
        AST_SHIFT_IN_RANGE: assert (int'(shamt) < int'(work_bits_i)); // R4
    end

endmodule

// File: rtl/mw_elem_unit.sv
module mw_elem_unit
    import mw_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic            pred_i,
    input  logic [2:0]      op_i,
    input  logic            sign_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [1:0]      a_w_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [1:0]      b_w_i,
    input  logic [1:0]      d_w_i,
    output logic            valid_o,
    output logic [XLEN-1:0] res_o
);

    localparam int unsigned BW   = $clog2(XLEN + 1);
    localparam int unsigned NEXT = 4;   // a, b, work->wide, wide->dest

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] res;
    } state_t;

    state_t s_d, s_q;

    logic [BW-1:0]   a_bits, b_bits, work_bits, d_bits;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] ext_in   [NEXT];
    logic [BW-1:0]   ext_bits [NEXT];
    logic [XLEN-1:0] ext_out  [NEXT];

    mw_width_arb #(.XLEN(XLEN)) u_arb (
        .a_w_i       (a_w_i),
        .b_w_i       (b_w_i),
        .a_bits_o    (a_bits),
        .b_bits_o    (b_bits),
        .work_bits_o (work_bits)
    );

    always_comb begin
        d_bits      = BW'(code_bits(d_w_i, XLEN));
        ext_in[0]   = a_i;
        ext_bits[0] = a_bits;
        ext_in[1]   = b_i;
        ext_bits[1] = b_bits;
        ext_in[2]   = raw;
        ext_bits[2] = work_bits;
        ext_in[3]   = ext_out[2];
        ext_bits[3] = d_bits;
    end

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        mw_extend #(.XLEN(XLEN)) u_ext (
            .val_i   (ext_in[g]),
            .nbits_i (ext_bits[g]),
            .sgn_i   (sign_i),
            .ext_o   (ext_out[g])
        );
    end

    mw_alu #(.XLEN(XLEN)) u_alu (
        .a_i         (ext_out[0]),
        .b_i         (ext_out[1]),
        .work_bits_i (work_bits),
        .op_i        (mw_op_e'(op_i)),
        .raw_o       (raw)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = valid_i & pred_i;
        if (valid_i && pred_i) begin
            s_d.res = ext_out[3];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.valid;
    assign res_o   = s_q.res;

    function automatic logic fill_ok(logic [XLEN-1:0] r, logic [1:0] c, logic s);
        int unsigned n;
        logic        f;
        n = code_bits(c, XLEN);
        f = s & r[n-1];
        for (int i = 0; i < int'(XLEN); i++) begin
            if (i >= int'(n) && r[i] != f) return 1'b0;
        end
        return 1'b1;
    endfunction

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_i) |=> valid_o); // R6
    AST_SKIP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && pred_i) |=> !valid_o); // R7
    AST_SKIP_HOLDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && pred_i) |=> $stable(res_o)); // R7
    AST_UPPER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> fill_ok(res_o, $past(d_w_i), $past(sign_i))); // R5

endmodule

// File: tb/tb_mw_elem_unit.sv
`timescale 1ns/1ps
module tb_mw_elem_unit;

    localparam int XL = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          valid_i, pred_i, sign_i;
    logic [2:0]    op_i;
    logic [XL-1:0] a_i, b_i;
    logic [1:0]    a_w_i, b_w_i, d_w_i;
    logic          valid_o;
    logic [XL-1:0] res_o;

    int errors = 0;
    int checks = 0;
    logic [XL-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    mw_elem_unit #(.XLEN(XL)) dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pred_i(pred_i),
        .op_i(op_i), .sign_i(sign_i), .a_i(a_i), .a_w_i(a_w_i),
        .b_i(b_i), .b_w_i(b_w_i), .d_w_i(d_w_i),
        .valid_o(valid_o), .res_o(res_o)
    );

    function automatic int wbits(logic [1:0] c);
        return (c == 2'd1) ? 8 : (c == 2'd2) ? 16 : (c == 2'd3) ? 32 : XL;
    endfunction

    function automatic logic [XL-1:0] fit(logic [XL-1:0] v, int n, logic s);
        logic [XL-1:0] m;
        if (n == XL) return v;
        m = (64'd1 << n) - 64'd1;
        if (s && v[n-1]) return v | ~m;
        return v & m;
    endfunction

    function automatic logic [XL-1:0] model(logic [2:0] op, logic s,
        logic [XL-1:0] a, logic [1:0] aw, logic [XL-1:0] b, logic [1:0] bw,
        logic [1:0] dw);
        int na = wbits(aw), nb = wbits(bw), w, sh;
        logic [XL-1:0] ea, eb, r;
        w  = (na > nb) ? na : nb;
        ea = fit(a, na, s);
        eb = fit(b, nb, s);
        sh = int'(eb % 64'(w));
        case (op)
            3'd0: r = ea + eb;
            3'd1: r = ea - eb;
            3'd2: r = ea & eb;
            3'd3: r = ea | eb;
            3'd4: r = ea ^ eb;
            3'd5: r = ea << sh;
            3'd6: r = fit(ea, w, 1'b0) >> sh;
            default: r = 64'($signed(fit(ea, w, 1'b1)) >>> sh);
        endcase
        r = fit(r, w, 1'b0);
        return fit(fit(r, w, s), wbits(dw), s);
    endfunction

    task automatic check(bit ok, string req, logic [XL-1:0] act, logic [XL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [2:0] op, logic s, logic [XL-1:0] a, logic [1:0] aw,
        logic [XL-1:0] b, logic [1:0] bw, logic [1:0] dw, logic p,
        bit lit, logic [XL-1:0] lit_exp, string tag);
        @(negedge clk);
        valid_i = 1'b1; pred_i = p; op_i = op; sign_i = s;
        a_i = a; a_w_i = aw; b_i = b; b_w_i = bw; d_w_i = dw;
        if (p) begin
            exp_q.push_back(lit ? lit_exp : model(op, s, a, aw, b, bw, dw));
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0; pred_i = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", res_o, '0);
            end else begin
                logic [XL-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(res_o == e, t, res_o, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [XL-1:0] held;
        rst_n = 1'b0; valid_i = 0; pred_i = 0; op_i = 0; sign_i = 0;
        a_i = 0; b_i = 0; a_w_i = 0; b_w_i = 0; d_w_i = 0;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R8 valid in reset", 64'(valid_o), 0);
        check(res_o == '0, "R8 res in reset", res_o, 0);
        rst_n = 1'b1;

        // R1/R2: 8-bit 0xFF plus 16-bit 1, dest 8 and 16
        drive(3'd0, 1'b1, 64'hABCD_00FF, 2'd1, 64'h1234_0001, 2'd2, 2'd1, 1'b1, 1'b1, 64'h0, "R1 R2 signed add");
        drive(3'd0, 1'b0, 64'hABCD_00FF, 2'd1, 64'h1234_0001, 2'd2, 2'd2, 1'b1, 1'b1, 64'h100, "R2 unsigned add");
        // R5: dest wider than working width, sign fill
        drive(3'd1, 1'b1, 64'h0, 2'd1, 64'h1, 2'd1, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 sub to full width");
        drive(3'd0, 1'b1, 64'h7F, 2'd3, 64'h1, 2'd3, 2'd1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FF80, "R5 truncate then sign");
        // R4: shift cases
        drive(3'd7, 1'b1, 64'h80, 2'd1, 64'h1, 2'd1, 2'd1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFC0, "R4 sra signed");
        drive(3'd7, 1'b0, 64'h80, 2'd1, 64'h1, 2'd1, 2'd1, 1'b1, 1'b1, 64'hC0, "R4 sra unsigned");
        drive(3'd5, 1'b0, 64'h1, 2'd1, 64'h9, 2'd1, 2'd0, 1'b1, 1'b1, 64'h2, "R4 sll modulo");
        drive(3'd6, 1'b0, 64'h8000_0000, 2'd3, 64'h21, 2'd1, 2'd3, 1'b1, 1'b1, 64'h4000_0000, "R4 srl modulo 32");
        // R3: logic ops
        drive(3'd2, 1'b0, 64'hF0F0, 2'd2, 64'hFF00, 2'd2, 2'd2, 1'b1, 1'b1, 64'hF000, "R3 and");
        drive(3'd3, 1'b0, 64'hF0F0, 2'd2, 64'h0F00, 2'd2, 2'd2, 1'b1, 1'b1, 64'hFFF0, "R3 or");
        drive(3'd4, 1'b0, 64'hF0F0, 2'd2, 64'hFF00, 2'd2, 2'd2, 1'b1, 1'b1, 64'h0FF0, "R3 xor");
        idle(); idle();

        // R7: skip holds previous result, no strobe
        drive(3'd0, 1'b0, 64'h5, 2'd0, 64'h6, 2'd0, 2'd0, 1'b1, 1'b1, 64'hB, "R6 add full");
        idle();
        held = res_o;
        drive(3'd0, 1'b0, 64'h100, 2'd0, 64'h1, 2'd0, 2'd0, 1'b0, 1'b0, 0, "R7");
        idle();
        check(valid_o == 1'b0, "R7 skip strobe", 64'(valid_o), 0);
        check(res_o == held, "R7 skip hold", res_o, held);

        // R6: back-to-back random stream with random predicates
        for (int k = 0; k < 400; k++) begin
            drive(3'($urandom), 1'($urandom), {$urandom, $urandom}, 2'($urandom),
                  {$urandom, $urandom}, 2'($urandom), 2'($urandom),
                  ($urandom % 4) != 0, 1'b0, 0, "R6 random stream");
        end
        idle(); idle(); idle();
        check(exp_q.size() == 0, "R6 all results seen", 64'(exp_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule